// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block sits beside a FIFO's storage and pointer logic and turns the FIFO's occupancy count into two programmable, active-low warning flags: one that warns when the FIFO is nearly drained and one that warns when it is nearly full. Each flag compares the occupancy against its own threshold register. The storage itself is outside the block. The block is told the occupancy and is told when a write-side or read-side clock event occurs, through a per-cycle tick on each side.

The two threshold registers take one of eight preset values at master reset. The preset is chosen by two select inputs together with the load strobe. After reset, software-free control logic can rewrite the thresholds over the parallel data bus, one word per register. It can also shift them in over a single serial line, least significant bit first. Either way the almost-empty threshold is written first and then the almost-full one. The thresholds can be read back over the parallel output bus in the same order.

A parity-position mode, fixed at master reset, decides whether bit 8 of a bus word is a parity bit that the offset skips. A timing mode, also fixed at master reset, selects either synchronous flags, where each flag moves only on its own side's tick, or asynchronous flags, where each flag is asserted by one side and released by the other. A partial reset keeps the thresholds, both modes and the load and readback order. It re-evaluates both flags at once.

Top module: `fifo_prog_flags`

## Requirements
- R1: `ae_n` is low when the occupancy `fill` is less than or equal to the almost-empty threshold. In synchronous mode it takes that value one cycle after a cycle with `rd_tick` high.
- R2: `af_n` is low when the free space (`DEPTH - fill`) is less than or equal to the almost-full threshold. In synchronous mode it takes that value one cycle after a cycle with `wr_tick` high.
- R3: In synchronous mode (`async_flags` low at master reset), `ae_n` changes only after a cycle with `rd_tick`, and `af_n` changes only after a cycle with `wr_tick`.
- R4: In asynchronous mode (`async_flags` high at master reset), `ae_n` goes low after an `rd_tick` cycle in which its condition holds, and returns high only after a `wr_tick` cycle in which its condition is false. `af_n` behaves the same way with the two ticks exchanged. Otherwise the flags hold.
- R5: While `rst_n` is low at a clock edge, both thresholds become 2^(k+3)-1, where k = {`ld`, `dflt_sel[1]`, `dflt_sel[0]`} read as an unsigned number, so the values run from 7 to 1023. At the same edge `ae_n` goes low, `af_n` goes high, `dout` clears, both load and readback order return to the almost-empty register, and both modes are captured.
- R6: A cycle with `wr_tick`, `ld` and `wen` high writes the mapped bus word into the threshold that is next in order, and the order then alternates between almost-empty and almost-full. If `sen` is also high in that cycle, the parallel load wins and the serial bit is dropped.
- R7: With the parity mode clear, offset bit i is `din[i]`, and `din` bits 16 and 17 are never used. With the parity mode set, offset bits 7..0 are `din[7:0]`, offset bit i for i of 8 or more is `din[i+1]`, and `din[8]` is skipped.
- R8: A cycle with `wr_tick`, `ld` and `sen` high and `wen` low shifts `si` in, least significant bit first. The threshold next in order changes only when the tenth bit (OFS_W bits) arrives, and the order then toggles.
- R9: A cycle with `rd_tick`, `ld` and `ren` high puts the next threshold in readback order on `dout` in the following cycle, and the readback order then alternates. The mapping is the inverse of R7: with the parity mode set, `dout[8]` is 0 and offset bits 8 and up appear from `dout[9]` upward. Unused bits are 0. The value read is the one held before any load in that same cycle, and `dout` holds between readbacks.
- R10: A cycle with `prs_n` low keeps both thresholds, both modes and both orders. It discards any partially shifted serial bits, ignores all load and readback strobes, and sets both flags from the current `fill` whatever the ticks.
- R11: Strobes without `ld`, and ticks without their strobes, leave both thresholds and `dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Master reset, synchronous, active low |
| prs_n | input | 1 | Partial reset, synchronous, active low |
| wr_tick | input | 1 | A write-side clock event occurs in this cycle |
| rd_tick | input | 1 | A read-side clock event occurs in this cycle |
| wen | input | 1 | Write strobe, used for parallel threshold loading |
| ren | input | 1 | Read strobe, used for threshold readback |
| sen | input | 1 | Serial shift strobe |
| ld | input | 1 | Threshold access qualifier; also the third preset select bit during master reset |
| si | input | 1 | Serial threshold data |
| dflt_sel | input | 2 | Lower two preset select bits, sampled during master reset |
| ilv_parity | input | 1 | Parity-skipping bus mapping, sampled during master reset |
| async_flags | input | 1 | Asynchronous flag timing, sampled during master reset |
| din | input | 18 | Parallel bus carrying threshold words |
| fill | input | CNT_W (11) | Number of words stored in the FIFO, 0 to DEPTH |
| dout | output | 18 | Threshold readback bus |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
Three things can fall in the same cycle. A threshold load can coincide with a flag update that reads the threshold, or with a readback. The flag must then use the old threshold, and the readback must show the pre-load value. In asynchronous mode both ticks can arrive together: the assert condition of one side and the release condition of the other are mutually exclusive, so the flag takes whichever side's condition holds. A long random phase drives `ld`, `wen`, `sen`, `ren`, both ticks and occasional partial resets independently, with `fill` pushed near both thresholds. A behavioural model judges every cycle's flags and readback value.

// File: rtl/fifo_prog_flags_pkg.sv
// Package: shared constants and types for the programmable flag unit.
// Assumes: the threshold bus is 18 bits wide and thresholds are at most 16 bits.
package fifo_prog_flags_pkg;

    // Width of the parallel threshold bus.
    localparam int BUS_W = 18;

    // Which threshold register an access targets.
    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;

endpackage

// File: rtl/fifo_flag_eval.sv
// Module: fifo_flag_eval
// Drives one active-low threshold flag from a precomputed condition.
// Synchronous mode: the flag follows the condition on its own-side tick.
// Asynchronous mode: the own-side tick can only assert, the other-side tick can only release.
// Assumes: cond is already evaluated against the threshold currently held.
module fifo_flag_eval #(
    parameter logic RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prs_n,
    input  logic async_mode,
    input  logic cond,
    input  logic set_tick,
    input  logic clr_tick,
    output logic flag_n
);

    // Flag register: reset level, partial-reset re-evaluation, then mode-dependent update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n <= RST_LVL;
        end else if (!prs_n) begin
            flag_n <= !cond;
        end else if (async_mode) begin
            if (set_tick && cond) begin
                flag_n <= 1'b0;
            end else if (clr_tick && !cond) begin
                flag_n <= 1'b1;
            end
        end else if (set_tick) begin
            flag_n <= !cond;
        end
    end

    // R3: synchronous flag moves only after its own tick.
    a_r3_sync_own_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (prs_n && !async_mode && !set_tick) |=> $stable(flag_n));

    // R4: asynchronous assertion on the own-side tick.
    a_r4_async_assert: assert property (@(posedge clk) disable iff (!rst_n)
        (prs_n && async_mode && set_tick && cond) |=> !flag_n);

    // R4: asynchronous flag stays low until an other-side tick.
    a_r4_async_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (prs_n && async_mode && !flag_n && !clr_tick) |=> !flag_n);

    // R10: partial reset re-evaluates the flag.
    a_r10_prs_eval: assert property (@(posedge clk) disable iff (!rst_n)
        (!prs_n && cond) |=> !flag_n);

endmodule

// File: rtl/fifo_ofs_regs.sv
// Module: fifo_ofs_regs
// Holds the almost-empty and almost-full thresholds. Applies reset presets,
// parallel and serial loading, and parallel readback with optional parity-bit skipping.
// Assumes: OFS_W <= 16; the strobes are sampled only in cycles with the matching tick.
module fifo_ofs_regs
    import fifo_prog_flags_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prs_n,
    input  logic             wr_tick,
    input  logic             rd_tick,
    input  logic             wen,
    input  logic             ren,
    input  logic             sen,
    input  logic             ld,
    input  logic             si,
    input  logic [1:0]       dflt_sel,
    input  logic             ilv_mode,
    input  logic [BUS_W-1:0] din,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs,
    output logic [BUS_W-1:0] dout
);

    localparam int SCNT_W = (OFS_W > 1) ? $clog2(OFS_W) : 1;
    localparam logic [SCNT_W-1:0] SCNT_LAST = SCNT_W'(OFS_W - 1);

    ofs_sel_e          wptr;
    ofs_sel_e          rptr;
    logic [SCNT_W-1:0] scnt;
    logic [OFS_W-1:0]  stage;
    logic [OFS_W-1:0]  par_val;
    logic [OFS_W-1:0]  ser_word;
    logic [OFS_W-1:0]  wr_val;
    logic [OFS_W-1:0]  dflt_val;
    logic [OFS_W-1:0]  rd_src;
    logic [BUS_W-1:0]  rd_ext;
    logic [BUS_W-1:0]  rd_bus;
    logic              ld_par;
    logic              ld_ser;
    logic              ser_done;
    logic              commit;
    logic              rd_bk;

    // Preset threshold: 2^(k+3)-1, with k = {ld, dflt_sel}.
    function automatic logic [OFS_W-1:0] preset(input logic [2:0] k);
        logic [OFS_W-1:0] v;
        for (int i = 0; i < OFS_W; i++) begin
            v[i] = (i < (int'(k) + 3));
        end
        return v;
    endfunction

    // Access strobes, all suppressed during partial reset.
    always_comb begin
        ld_par   = prs_n && wr_tick && ld && wen;
        ld_ser   = prs_n && wr_tick && ld && sen && !wen;
        rd_bk    = prs_n && rd_tick && ld && ren;
        ser_done = ld_ser && (scnt == SCNT_LAST);
        commit   = ld_par || ser_done;
        dflt_val = preset({ld, dflt_sel});
    end

    // Bus word to threshold, skipping bit 8 when the parity mode is set.
    always_comb begin
        for (int i = 0; i < OFS_W; i++) begin
            par_val[i] = (ilv_mode && i >= 8) ? din[i+1] : din[i];
        end
        ser_word = {si, stage[OFS_W-1:1]};
        wr_val   = ld_par ? par_val : ser_word;
    end

    // Threshold to bus word, the inverse of the load mapping.
    always_comb begin
        rd_src = (rptr == SEL_AE) ? ae_ofs : af_ofs;
        rd_ext = BUS_W'(rd_src);
        rd_bus = rd_ext;
        if (ilv_mode) begin
            rd_bus[8] = 1'b0;
            for (int j = 9; j < BUS_W; j++) begin
                rd_bus[j] = rd_ext[j-1];
            end
        end
    end

    // Threshold registers: preset at master reset, written on a completed load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_ofs <= dflt_val;
            af_ofs <= dflt_val;
        end else if (commit) begin
            if (wptr == SEL_AE) begin
                ae_ofs <= wr_val;
            end else begin
                af_ofs <= wr_val;
            end
        end
    end

    // Load order pointer: starts at almost-empty and toggles per completed load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= SEL_AE;
        end else if (commit) begin
            wptr <= (wptr == SEL_AE) ? SEL_AF : SEL_AE;
        end
    end

    // Serial bit counter: cleared by either reset, wraps on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !prs_n) begin
            scnt <= '0;
        end else if (ld_ser) begin
            scnt <= ser_done ? '0 : scnt + 1'b1;
        end
    end

    // Serial staging shifter, LSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (ld_ser) begin
            stage <= ser_word;
        end
    end

    // Readback register and readback order pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            rptr <= SEL_AE;
        end else if (rd_bk) begin
            dout <= rd_bus;
            rptr <= (rptr == SEL_AE) ? SEL_AF : SEL_AE;
        end
    end

    // R11: thresholds only move on a load strobe qualified by ld.
    a_r11_ofs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!prs_n || !(wr_tick && ld && (wen || sen))) |=> ($stable(ae_ofs) && $stable(af_ofs)));

    // R9: readback bus holds between readbacks.
    a_r9_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(prs_n && rd_tick && ld && ren) |=> $stable(dout));

    // R6: each parallel load advances the load order.
    a_r6_order_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (prs_n && wr_tick && ld && wen) |=> (wptr != $past(wptr)));

endmodule

// File: rtl/fifo_prog_flags.sv
// Module: fifo_prog_flags (top)
// Programmable almost-empty / almost-full flag unit for a FIFO of DEPTH words.
// Captures the modes at master reset, holds the thresholds, and evaluates both flags.
// Assumes: fill never exceeds DEPTH; DEPTH <= 65536.
module fifo_prog_flags
    import fifo_prog_flags_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int OFS_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prs_n,
    input  logic             wr_tick,
    input  logic             rd_tick,
    input  logic             wen,
    input  logic             ren,
    input  logic             sen,
    input  logic             ld,
    input  logic             si,
    input  logic [1:0]       dflt_sel,
    input  logic             ilv_parity,
    input  logic             async_flags,
    input  logic [17:0]      din,
    input  logic [CNT_W-1:0] fill,
    output logic [17:0]      dout,
    output logic             ae_n,
    output logic             af_n
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic             ilv_q;
    logic             async_q;
    logic [OFS_W-1:0] ae_ofs;
    logic [OFS_W-1:0] af_ofs;
    logic [CNT_W-1:0] free_cnt;
    logic             ae_cond;
    logic             af_cond;

    // Mode capture: both modes are sampled only during master reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ilv_q   <= ilv_parity;
            async_q <= async_flags;
        end
    end

    // Threshold comparisons against stored and free words.
    always_comb begin
        free_cnt = DEPTH_C - fill;
        ae_cond  = fill <= CNT_W'(ae_ofs);
        af_cond  = free_cnt <= CNT_W'(af_ofs);
    end

    fifo_ofs_regs #(
        .OFS_W (OFS_W)
    ) u_ofs (
        .clk      (clk),
        .rst_n    (rst_n),
        .prs_n    (prs_n),
        .wr_tick  (wr_tick),
        .rd_tick  (rd_tick),
        .wen      (wen),
        .ren      (ren),
        .sen      (sen),
        .ld       (ld),
        .si       (si),
        .dflt_sel (dflt_sel),
        .ilv_mode (ilv_q),
        .din      (din),
        .ae_ofs   (ae_ofs),
        .af_ofs   (af_ofs),
        .dout     (dout)
    );

    // Almost-empty: asserted by the read side, released by the write side.
    fifo_flag_eval #(
        .RST_LVL (1'b0)
    ) u_ae (
        .clk        (clk),
        .rst_n      (rst_n),
        .prs_n      (prs_n),
        .async_mode (async_q),
        .cond       (ae_cond),
        .set_tick   (rd_tick),
        .clr_tick   (wr_tick),
        .flag_n     (ae_n)
    );

    // Almost-full: asserted by the write side, released by the read side.
    fifo_flag_eval #(
        .RST_LVL (1'b1)
    ) u_af (
        .clk        (clk),
        .rst_n      (rst_n),
        .prs_n      (prs_n),
        .async_mode (async_q),
        .cond       (af_cond),
        .set_tick   (wr_tick),
        .clr_tick   (rd_tick),
        .flag_n     (af_n)
    );

    // R5: flags leave master reset with almost-empty asserted and almost-full clear.
    a_r5_reset_flags: assert property (@(posedge clk)
        (!rst_n) |=> (!ae_n && af_n));

endmodule

// File: tb/tb_fifo_prog_flags.sv
// Bench for fifo_prog_flags: a behavioural reference model compared on every clock.
module tb_fifo_prog_flags;

    localparam int DEPTH = 1024;
    localparam int OFS_W = 10;
    localparam int CNT_W = 11;
    localparam int MASK  = (1 << OFS_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             prs_n = 1'b1;
    logic             wr_tick = 1'b0;
    logic             rd_tick = 1'b0;
    logic             wen = 1'b0;
    logic             ren = 1'b0;
    logic             sen = 1'b0;
    logic             ld = 1'b0;
    logic             si = 1'b0;
    logic [1:0]       dflt_sel = 2'd0;
    logic             ilv_parity = 1'b0;
    logic             async_flags = 1'b0;
    logic [17:0]      din = '0;
    logic [CNT_W-1:0] fill = '0;
    logic [17:0]      dout;
    logic             ae_n;
    logic             af_n;

    fifo_prog_flags #(.DEPTH(DEPTH)) dut (
        .clk (clk), .rst_n (rst_n), .prs_n (prs_n), .wr_tick (wr_tick),
        .rd_tick (rd_tick), .wen (wen), .ren (ren), .sen (sen), .ld (ld),
        .si (si), .dflt_sel (dflt_sel), .ilv_parity (ilv_parity),
        .async_flags (async_flags), .din (din), .fill (fill), .dout (dout),
        .ae_n (ae_n), .af_n (af_n)
    );

    always #5 clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string cur_req = "R5";

    // Reference model state.
    int m_ae, m_af, m_wp, m_rp, m_sc, m_stg, m_dout;
    bit m_aen, m_afn, m_ilv, m_async;

    function automatic int map_in(int d, bit ilv);
        if (ilv) return ((d & 'hFF) | ((d >> 9) << 8)) & MASK;
        return d & MASK;
    endfunction

    function automatic int map_out(int v, bit ilv);
        if (ilv) return (v & 'hFF) | ((v >> 8) << 9);
        return v;
    endfunction

    task automatic model_write(int v);
        if (m_wp == 0) m_ae = v; else m_af = v;
        m_wp ^= 1;
    endtask

    // One clock edge of the model, from the inputs present at that edge.
    task automatic model_step();
        int  f;
        bit  aec, afc;
        f = int'(fill);
        if (!rst_n) begin
            m_ae = (1 << (int'(ld) * 4 + int'(dflt_sel) + 3)) - 1;
            m_ae &= MASK;
            m_af = m_ae;
            m_aen = 0; m_afn = 1; m_wp = 0; m_rp = 0; m_sc = 0; m_stg = 0; m_dout = 0;
            m_ilv = ilv_parity; m_async = async_flags;
            return;
        end
        aec = (f <= m_ae);
        afc = ((DEPTH - f) <= m_af);
        if (!prs_n) begin
            m_aen = !aec; m_afn = !afc; m_sc = 0;
            return;
        end
        if (m_async) begin
            if (rd_tick && aec) m_aen = 0; else if (wr_tick && !aec) m_aen = 1;
            if (wr_tick && afc) m_afn = 0; else if (rd_tick && !afc) m_afn = 1;
        end else begin
            if (rd_tick) m_aen = !aec;
            if (wr_tick) m_afn = !afc;
        end
        if (rd_tick && ld && ren) begin
            m_dout = map_out((m_rp == 0) ? m_ae : m_af, m_ilv);
            m_rp ^= 1;
        end
        if (wr_tick && ld && wen) begin
            model_write(map_in(int'(din), m_ilv));
        end else if (wr_tick && ld && sen) begin
            m_stg = (m_stg >> 1) | (int'(si) << (OFS_W - 1));
            m_sc++;
            if (m_sc == OFS_W) begin
                model_write(m_stg);
                m_sc = 0;
            end
        end
    endtask

    task automatic check_bit(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Advance one clock: model at the edge, compare away from it.
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_bit("ae_n", int'(ae_n), int'(m_aen));
        check_bit("af_n", int'(af_n), int'(m_afn));
        check_bit("dout", int'(dout), m_dout);
    endtask

    task automatic idle();
        wr_tick = 0; rd_tick = 0; wen = 0; ren = 0; sen = 0; ld = 0; si = 0; prs_n = 1;
    endtask

    task automatic mreset(bit ldsel, int sel, bit ilv, bit asy);
        idle();
        rst_n = 0; ld = ldsel; dflt_sel = 2'(sel); ilv_parity = ilv; async_flags = asy;
        fill = '0;
        repeat (2) cyc();
        rst_n = 1; ld = 0;
        cyc();
    endtask

    task automatic readback2();
        idle(); ld = 1; ren = 1; rd_tick = 1;
        cyc(); cyc();
        idle(); cyc();
    endtask

    task automatic pload(int d);
        idle(); ld = 1; wen = 1; wr_tick = 1; din = 18'(d);
        cyc();
        idle();
    endtask

    task automatic sload(int v, int nbits);
        for (int b = 0; b < nbits; b++) begin
            idle(); ld = 1; sen = 1; wr_tick = 1; si = v[b];
            cyc();
            idle(); ld = 1; sen = 1; si = ~v[b]; // no tick: R11 no shift
            cyc();
        end
        idle();
    endtask

    function automatic int near_fill(int a, int f);
        int r;
        r = $urandom_range(5, 0);
        case (r)
            0: return $urandom_range(DEPTH, 0);
            1: return (a > 0) ? a - 1 : 0;
            2: return a;
            3: return (a < DEPTH) ? a + 1 : DEPTH;
            4: return DEPTH - f;
            default: return (DEPTH - f - 1 >= 0) ? DEPTH - f - 1 : 0;
        endcase
    endfunction

    task automatic rand_flags(int n, bit strobes);
        for (int i = 0; i < n; i++) begin
            idle();
            wr_tick = 1'($urandom_range(1, 0));
            rd_tick = 1'($urandom_range(1, 0));
            fill = CNT_W'(near_fill(m_ae, m_af));
            if (strobes) begin
                ld  = 1'($urandom_range(1, 0));
                wen = ($urandom_range(5, 0) == 0);
                sen = 1'($urandom_range(1, 0));
                ren = 1'($urandom_range(1, 0));
                si  = 1'($urandom_range(1, 0));
                din = 18'($urandom_range(18'h3FFFF, 0));
                prs_n = ($urandom_range(40, 0) != 0);
            end else begin
                prs_n = ($urandom_range(60, 0) != 0);
            end
            cyc();
        end
        idle();
    endtask

    initial begin
        // R5: preset index 0 gives 7 for both thresholds; flags at reset level.
        cur_req = "R5";
        mreset(0, 0, 0, 0);
        readback2();
        // R5: preset index 5 ({ld=1, sel=01}) gives 255.
        mreset(1, 1, 0, 0);
        readback2();
        // R5: preset index 7 gives 1023.
        mreset(1, 3, 0, 0);
        readback2();

        // R1 R2 R3: synchronous flags around both thresholds.
        mreset(1, 1, 0, 0);
        cur_req = "R1/R2/R3";
        rand_flags(500, 0);

        // R6 R7: parallel loads without parity skipping; bits 16 and 17 ignored.
        cur_req = "R6/R7";
        pload(18'h30105);
        pload(18'h00020);
        cur_req = "R9";
        readback2();
        // R9: readback in the same cycle as a load shows the old value.
        idle(); ld = 1; wen = 1; wr_tick = 1; ren = 1; rd_tick = 1; din = 18'h00040;
        cyc();
        idle(); cyc();
        // R11: strobes without ld change nothing.
        cur_req = "R11";
        idle(); wen = 1; sen = 1; ren = 1; wr_tick = 1; rd_tick = 1; din = 18'h3FFFF;
        repeat (4) cyc();
        readback2();

        // R7: parity-skipping mapping, bit 8 dropped on load and zero on readback.
        mreset(0, 2, 1, 0);
        cur_req = "R7";
        pload(18'h003FF);
        pload(18'h00100);
        readback2();
        pload(18'h3FEFF);
        pload(18'h20000);
        readback2();

        // R8: serial loads LSB first, partial shift discarded by partial reset (R10).
        mreset(0, 0, 0, 0);
        cur_req = "R8";
        sload(10'h2A5, OFS_W);
        sload(10'h13C, OFS_W);
        readback2();
        cur_req = "R10";
        sload(10'h3FF, 5);
        idle(); prs_n = 0; fill = CNT_W'(3); cyc();
        idle(); cyc();
        sload(10'h055, OFS_W);
        readback2();
        // R6: parallel wins over serial in the same cycle.
        cur_req = "R6";
        idle(); ld = 1; wen = 1; sen = 1; si = 1; wr_tick = 1; din = 18'h00111;
        cyc();
        idle(); readback2();

        // R4: asynchronous flag timing.
        mreset(1, 0, 0, 1);
        cur_req = "R4";
        rand_flags(600, 0);

        // R4/R6/R8/R9/R10: everything random, including same-cycle collisions.
        cur_req = "R6/R8/R9/R10";
        rand_flags(1200, 1);
        mreset(0, 3, 1, 0);
        rand_flags(1200, 1);
        mreset(1, 2, 1, 1);
        cur_req = "R4/R10";
        rand_flags(1200, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule